// File: doc/BRIEF.md
# Multi-Polynomial CRC Unit

This block computes a cyclic redundancy check over a stream of words written by software through a small register bus. A configuration word picks one of four generator polynomials: CCITT 16-bit, an 8-bit code, a 16-bit code and a 32-bit code. The same word sets how many bytes of each write count (one, two or four), whether each byte is inverted and/or bit-reversed before use, and whether the result is bit-reversed and/or inverted when read.

Software first writes the seed register, then writes the configuration word with the reload and run bits set. It then writes data words and reads the checksum register. A multi-byte write is folded into the CRC least significant byte first, and the whole write completes in one clock. The bus read path is registered, so a read returns data one cycle after the address is presented. The register word addresses are 0 (control), 1 (seed), 2 (data) and 3 (checksum).

Top module: `crc_unit`

## Requirements
- R1: After reset the control register reads 0x2000_0000 and the seed register reads 0xFFFF_FFFF. The CRC state holds 0xFFFF, so the checksum reads 0x0000_FFFF.
- R2: Mode code 2'b11 in control bits [31:30] runs the 32-bit code with generator 0x04C11DB7, shifting most significant bit first. With seed 0xFFFF_FFFF and the bytes "123456789", the checksum is 0x0376E6E7.
- R3: Mode code 2'b00 runs the CCITT code with generator 0x1021. With seed 0xFFFF_FFFF masked to 16 bits, "123456789" gives 0x29B1.
- R4: Mode code 2'b01 runs the 8-bit code with generator 0x07, and mode code 2'b10 runs the 16-bit code with generator 0x8005. With a zero seed, "123456789" gives 0xF4 and 0xFEE8 respectively.
- R5: Control bits [29:28] set the bytes used per data write: 00 uses bits [7:0], 01 uses bits [15:0], and 1x uses all 32 bits. Bytes are taken least significant first, and unused upper bits have no effect.
- R6: Control bit 27 makes the checksum read back as the 1's complement of the result within the mode's width.
- R7: Control bit 26 inverts every used data byte before it enters the CRC, so a write of byte b matches a write of ~b with the bit cleared.
- R8: Control bit 24 reverses the bit order inside each used data byte. Control bit 25 reverses the result across the mode's width before any complement is applied.
- R9: Writing control with bit 1 set raises the reload bit. On the next clock the state loads from the seed masked to the mode width, and the bit clears. The control read shows bit 1 set during that one cycle only.
- R10: A data write while control bit 0 (run) is clear leaves the CRC state unchanged.
- R11: Control bits [23:2] read as zero whatever was written, and the data address reads as zero.
- R12: Checksum bits above the selected width read as zero. A read issued in the cycle after a data write returns the updated checksum one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after the address |

## Verification
The bench builds the block with its defaults: a 32-bit bus, two address bits and the standard generator constants. Those values make the published check values of "123456789" for every mode and reflection setting directly comparable. A behavioural model made of integer arithmetic and byte loops predicts every read, cycle by cycle. This reaches mode switches without reload, masked seeds, upper-bit garbage in narrow writes and writes while the engine is stopped.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int CRC_MAX_W = 32;
  localparam int CFG_W     = 8;

  typedef enum logic [1:0] {
    MODE_CCITT = 2'd0,
    MODE_C8    = 2'd1,
    MODE_C16   = 2'd2,
    MODE_C32   = 2'd3
  } crc_mode_e;

  // Field order matches control bits [31:24]
  typedef struct packed {
    crc_mode_e  mode;
    logic [1:0] len;
    logic       sum_inv;
    logic       din_inv;
    logic       sum_rev;
    logic       din_rev;
  } crc_cfg_t;

  localparam crc_cfg_t CFG_RESET = '{MODE_CCITT, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0};

  function automatic logic [5:0] mode_width(crc_mode_e m);
    case (m)
      MODE_C8:  return 6'd8;
      MODE_C32: return 6'd32;
      default:  return 6'd16;
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] mode_mask(crc_mode_e m);
    case (m)
      MODE_C8:  return 32'h0000_00FF;
      MODE_C32: return 32'hFFFF_FFFF;
      default:  return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] len_bytes(logic [1:0] l);
    case (l)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Fold one byte, MSB first, into a CRC of width topi+1
  function automatic logic [CRC_MAX_W-1:0] crc_byte(
    input logic [CRC_MAX_W-1:0] s_in,
    input logic [7:0]           b,
    input logic [CRC_MAX_W-1:0] poly,
    input logic [CRC_MAX_W-1:0] mask,
    input logic [4:0]           topi
  );
    logic [CRC_MAX_W-1:0] s;
    logic fb;
    s = s_in;
    for (int k = 7; k >= 0; k--) begin
      fb = s[topi] ^ b[k];
      s  = (s << 1) & mask;
      if (fb) s = s ^ poly;
    end
    return s;
  endfunction

endpackage

// File: rtl/crc_regs.sv
module crc_regs
  import crc_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] SEED_INIT = '1,
  parameter logic [ADDR_W-1:0] A_CTRL    = 0,
  parameter logic [ADDR_W-1:0] A_SEED    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output crc_cfg_t          cfg,
  output logic              run_en,
  output logic              reload,
  output logic [DATA_W-1:0] seed,
  output logic [DATA_W-1:0] ctrl_word
);

  localparam int RSV_W = DATA_W - CFG_W - 2;

  logic ctrl_wr, seed_wr;
  logic unused_rsv;

  assign ctrl_wr    = bus_we && (bus_addr == A_CTRL);
  assign seed_wr    = bus_we && (bus_addr == A_SEED);
  assign unused_rsv = ^bus_wdata[DATA_W-CFG_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      run_en <= 1'b0;
      reload <= 1'b0;
      seed   <= SEED_INIT;
    end else begin
      reload <= 1'b0;
      if (ctrl_wr) begin
        cfg    <= crc_cfg_t'(bus_wdata[DATA_W-1 -: CFG_W]);
        run_en <= bus_wdata[0];
        reload <= bus_wdata[1];
      end
      if (seed_wr) seed <= bus_wdata;
    end
  end

  assign ctrl_word = {cfg, {RSV_W{1'b0}}, reload, run_en};

endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] P_CCITT = 32'h0000_1021,
  parameter logic [31:0] P_C8    = 32'h0000_0007,
  parameter logic [31:0] P_C16   = 32'h0000_8005,
  parameter logic [31:0] P_C32   = 32'h04C1_1DB7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  crc_mode_e            mode,
  input  logic [1:0]           len,
  input  logic                 din_inv,
  input  logic                 din_rev,
  input  logic                 run_en,
  input  logic                 reload,
  input  logic [DATA_W-1:0]    seed,
  input  logic                 din_valid,
  input  logic [DATA_W-1:0]    din,
  output logic [CRC_MAX_W-1:0] crc_state
);

  localparam int LANES = DATA_W / 8;

  logic [CRC_MAX_W-1:0] poly, mask;
  logic [4:0]           topi;
  logic [2:0]           nbytes;

  always_comb begin
    case (mode)
      MODE_C8:  poly = P_C8;
      MODE_C16: poly = P_C16;
      MODE_C32: poly = P_C32;
      default:  poly = P_CCITT;
    endcase
    mask   = mode_mask(mode);
    topi   = 5'(mode_width(mode) - 6'd1);
    nbytes = len_bytes(len);
  end

  logic [7:0]           lane_raw [LANES];
  logic [7:0]           lane_rev [LANES];
  logic [7:0]           lane_in  [LANES];
  logic [CRC_MAX_W-1:0] chain    [LANES+1];

  assign chain[0] = crc_state;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_raw[g] = din[8*g +: 8] ^ {8{din_inv}};
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign lane_rev[g][b] = lane_raw[g][7-b];
    end
    assign lane_in[g]  = din_rev ? lane_rev[g] : lane_raw[g];
    assign chain[g+1]  = (32'(g) < 32'(nbytes))
                         ? crc_byte(chain[g], lane_in[g], poly, mask, topi)
                         : chain[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_state <= SEED_RESET_MASKED;
    end else if (reload) begin
      crc_state <= CRC_MAX_W'(seed) & mask;
    end else if (din_valid && run_en) begin
      crc_state <= chain[LANES];
    end
  end

  localparam logic [CRC_MAX_W-1:0] SEED_RESET_MASKED = 32'h0000_FFFF;

endmodule

// File: rtl/crc_out.sv
module crc_out
  import crc_pkg::*;
(
  input  crc_mode_e            mode,
  input  logic                 sum_inv,
  input  logic                 sum_rev,
  input  logic [CRC_MAX_W-1:0] crc_state,
  output logic [CRC_MAX_W-1:0] checksum
);

  logic [CRC_MAX_W-1:0] mask, masked, flipped, picked;
  logic [5:0]           wid;

  always_comb begin
    mask    = mode_mask(mode);
    wid     = mode_width(mode);
    masked  = crc_state & mask;
    flipped = '0;
    for (int i = 0; i < CRC_MAX_W; i++) begin
      if (6'(i) < wid) flipped[i] = masked[wid - 6'(i) - 6'd1];
    end
    picked   = sum_rev ? flipped : masked;
    checksum = sum_inv ? (~picked & mask) : picked;
  end

endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] SEED_INIT = '1,
  parameter logic [31:0]       P_CCITT   = 32'h0000_1021,
  parameter logic [31:0]       P_C8      = 32'h0000_0007,
  parameter logic [31:0]       P_C16     = 32'h0000_8005,
  parameter logic [31:0]       P_C32     = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(3);

  crc_cfg_t             cfg;
  logic                 run_en, reload;
  logic [DATA_W-1:0]    seed, ctrl_word;
  logic [CRC_MAX_W-1:0] crc_state, checksum;
  logic [1:0]           cur_mode;
  logic                 data_wr;

  assign cur_mode = cfg.mode;
  assign data_wr  = bus_we && (bus_addr == A_DATA);

  crc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED_INIT(SEED_INIT),
    .A_CTRL(A_CTRL), .A_SEED(A_SEED)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg(cfg), .run_en(run_en), .reload(reload),
    .seed(seed), .ctrl_word(ctrl_word)
  );

  crc_core #(
    .DATA_W(DATA_W), .P_CCITT(P_CCITT), .P_C8(P_C8),
    .P_C16(P_C16), .P_C32(P_C32)
  ) u_core (
    .clk(clk), .rst(rst), .mode(cfg.mode), .len(cfg.len),
    .din_inv(cfg.din_inv), .din_rev(cfg.din_rev), .run_en(run_en),
    .reload(reload), .seed(seed), .din_valid(data_wr), .din(bus_wdata),
    .crc_state(crc_state)
  );

  crc_out u_out (
    .mode(cfg.mode), .sum_inv(cfg.sum_inv), .sum_rev(cfg.sum_rev),
    .crc_state(crc_state), .checksum(checksum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_word;
        A_SEED:  bus_rdata <= seed;
        A_SUM:   bus_rdata <= DATA_W'(checksum);
        default: bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk
  import crc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 reload,
  input logic                 run_en,
  input logic [DATA_W-1:0]    seed,
  input logic [1:0]           cur_mode,
  input logic [CRC_MAX_W-1:0] crc_state,
  input logic [CRC_MAX_W-1:0] checksum
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!run_en && !reload));

  // R11
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(0)) |-> (bus_rdata[DATA_W-9:2] == '0));

  // R9
  reload_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
    (reload && !(bus_we && bus_addr == ADDR_W'(0) && bus_wdata[1])) |=> !reload);

  // R9
  reload_loads_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> (crc_state == (CRC_MAX_W'($past(seed)) & mode_mask(crc_mode_e'($past(cur_mode))))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !reload) |=> $stable(crc_state));

  // R12
  sum_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 2'b01) |-> (checksum[CRC_MAX_W-1:8] == '0));

endmodule

bind crc_unit crc_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reload(reload),
  .run_en(run_en), .seed(seed), .cur_mode(cur_mode),
  .crc_state(crc_state), .checksum(checksum)
);

// File: tb/crc_unit_bench.sv
`timescale 1ns/1ps
module crc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crc_unit u_crc_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // behavioural model state
  logic [7:0]  m_cfg;   // [7:6] mode [5:4] len [3] sum inv [2] din inv [1] sum rev [0] din rev
  logic        m_en, m_rl;
  logic [31:0] m_seed, m_state;

  function automatic int m_width(logic [1:0] m);
    return (m == 2'd1) ? 8 : (m == 2'd3) ? 32 : 16;
  endfunction

  function automatic longint m_poly(logic [1:0] m);
    case (m)
      2'd0: return 64'h1021;
      2'd1: return 64'h07;
      2'd2: return 64'h8005;
      default: return 64'h04C11DB7;
    endcase
  endfunction

  function automatic logic [31:0] m_sum();
    int w = m_width(m_cfg[7:6]);
    longint mk = (64'd1 << w) - 1;
    longint v = longint'(m_state) & mk;
    longint r = 0;
    if (m_cfg[1]) begin
      for (int i = 0; i < w; i++) if ((v >> i) & 1) r = r | (64'd1 << (w - 1 - i));
      v = r;
    end
    if (m_cfg[3]) v = (~v) & mk;
    return v[31:0];
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {m_cfg, 22'd0, m_rl, m_en};
      2'd1: return m_seed;
      2'd2: return 32'd0;
      default: return m_sum();
    endcase
  endfunction

  task automatic m_step(logic [1:0] a, logic w, logic [31:0] d);
    int wid = m_width(m_cfg[7:6]);
    longint mk = (64'd1 << wid) - 1;
    longint st = longint'(m_state);
    int nb = (m_cfg[5:4] == 2'b00) ? 1 : (m_cfg[5:4] == 2'b01) ? 2 : 4;
    if (m_rl) begin
      st = longint'(m_seed) & mk;
    end else if (w && a == 2'd2 && m_en) begin
      for (int j = 0; j < nb; j++) begin
        int bv = (d >> (8 * j)) & 8'hFF;
        int rb = 0;
        if (m_cfg[2]) bv = bv ^ 8'hFF;
        if (m_cfg[0]) begin
          for (int i = 0; i < 8; i++) if ((bv >> i) & 1) rb = rb | (1 << (7 - i));
          bv = rb;
        end
        for (int k = 7; k >= 0; k--) begin
          bit top = ((st >> (wid - 1)) & 1) != 0;
          bit inb = ((bv >> k) & 1) != 0;
          st = (st * 2) & mk;
          if (top != inb) st = st ^ m_poly(m_cfg[7:6]);
        end
      end
    end
    m_state = st[31:0];
    m_rl = 1'b0;
    if (w && a == 2'd0) begin
      m_cfg = d[31:24];
      m_en  = d[0];
      m_rl  = d[1];
    end
    if (w && a == 2'd1) m_seed = d;
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one bus cycle, model-compared on the clock
  task automatic cycle(logic [1:0] a, logic w, logic [31:0] d, string tag);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d;
    exp = m_read(a);
    m_step(a, w, d);
    @(posedge clk);
    #1;
    bus_we = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr_ctrl(logic [31:0] d, string tag);
    cycle(2'd0, 1'b1, d, tag);
    cycle(2'd3, 1'b0, 32'd0, tag);
  endtask

  task automatic feed_digits(string tag);
    for (int i = 1; i <= 9; i++) cycle(2'd2, 1'b1, 32'h30 + i, tag);
  endtask

  task automatic expect_sum(logic [31:0] v, string tag);
    cycle(2'd3, 1'b0, 32'd0, tag);
    check(tag, bus_rdata, v);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] sum_a;
    m_cfg = 8'h20; m_en = 0; m_rl = 0; m_seed = '1; m_state = 32'h0000_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    cycle(2'd0, 1'b0, 0, "R1"); check("R1", bus_rdata, 32'h2000_0000);
    cycle(2'd1, 1'b0, 0, "R1"); check("R1", bus_rdata, 32'hFFFF_FFFF);
    expect_sum(32'h0000_FFFF, "R1");

    // R2 32-bit code, byte writes
    wr_ctrl(32'hC000_0003, "R2");
    feed_digits("R2");
    expect_sum(32'h0376_E6E7, "R2");

    // R6 complemented result
    wr_ctrl(32'hC800_0001, "R6");
    expect_sum(32'hFC89_1918, "R6");

    // R5 full-word writes then a byte
    wr_ctrl(32'hE000_0003, "R5");
    cycle(2'd2, 1'b1, 32'h3433_3231, "R5");
    cycle(2'd2, 1'b1, 32'h3837_3635, "R5");
    wr_ctrl(32'hC000_0001, "R5");
    cycle(2'd2, 1'b1, 32'hDEAD_BE39, "R5");
    expect_sum(32'h0376_E6E7, "R5");

    // R3 CCITT with 16-bit writes carrying upper garbage (R5)
    wr_ctrl(32'h1000_0003, "R3");
    cycle(2'd2, 1'b1, 32'hABCD_3231, "R5");
    cycle(2'd2, 1'b1, 32'h5A5A_3433, "R5");
    cycle(2'd2, 1'b1, 32'hFFFF_3635, "R5");
    cycle(2'd2, 1'b1, 32'h0000_3837, "R5");
    wr_ctrl(32'h0000_0001, "R3");
    cycle(2'd2, 1'b1, 32'hFFFF_FF39, "R5");
    expect_sum(32'h0000_29B1, "R3");

    // R4 8-bit and 16-bit codes, zero seed
    cycle(2'd1, 1'b1, 32'h0, "R4");
    wr_ctrl(32'h4000_0003, "R4");
    feed_digits("R4");
    expect_sum(32'h0000_00F4, "R4");
    wr_ctrl(32'h8000_0003, "R4");
    feed_digits("R4");
    expect_sum(32'h0000_FEE8, "R4");

    // R8 reflected variants
    wr_ctrl(32'h0300_0003, "R8");
    feed_digits("R8");
    expect_sum(32'h0000_2189, "R8");
    cycle(2'd1, 1'b1, 32'hFFFF_FFFF, "R8");
    wr_ctrl(32'hCB00_0003, "R8");
    feed_digits("R8");
    expect_sum(32'hCBF4_3926, "R8");

    // R7 data inversion equals pre-inverted data
    wr_ctrl(32'hC400_0003, "R7");
    cycle(2'd2, 1'b1, 32'h31, "R7");
    cycle(2'd2, 1'b1, 32'h32, "R7");
    cycle(2'd3, 1'b0, 0, "R7"); sum_a = bus_rdata;
    wr_ctrl(32'hC000_0003, "R7");
    cycle(2'd2, 1'b1, 32'hCE, "R7");
    cycle(2'd2, 1'b1, 32'hCD, "R7");
    expect_sum(sum_a, "R7");

    // R9 reload pulse, masked seed; R12 upper bits zero
    cycle(2'd1, 1'b1, 32'h1234_5678, "R9");
    cycle(2'd0, 1'b1, 32'h4000_0003, "R9");
    cycle(2'd0, 1'b0, 0, "R9"); check("R9", bus_rdata, 32'h4000_0003);
    cycle(2'd0, 1'b0, 0, "R9"); check("R9", bus_rdata, 32'h4000_0001);
    expect_sum(32'h0000_0078, "R12");

    // R10 writes ignored while stopped
    wr_ctrl(32'hC000_0002, "R10");
    cycle(2'd2, 1'b1, 32'h55, "R10");
    cycle(2'd2, 1'b1, 32'hAA, "R10");
    expect_sum(32'h1234_5678, "R10");

    // R11 reserved bits and data address read zero
    wr_ctrl(32'h00FF_FFFD, "R11");
    cycle(2'd0, 1'b0, 0, "R11"); check("R11", bus_rdata, 32'h0000_0001);
    cycle(2'd2, 1'b0, 0, "R11"); check("R11", bus_rdata, 32'h0);

    // R12 mixed traffic, model compared each clock
    for (int n = 0; n < 60; n++) begin
      logic [1:0]  a = 2'($urandom_range(0, 3));
      logic [31:0] d = $urandom();
      if (a == 2'd0) d[1] = d[1] & d[2];
      cycle(a, 1'($urandom_range(0, 1)), d, "R12");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule